// File: doc/BRIEF.md
# Serial Wiper Command Controller

This block is the digital core of a serially programmed potentiometer. A host talks to it over a 4-wire SPI slave link (chip select, serial clock, data in, data out) using 24-bit frames. Each frame carries a 4-bit operation code, a 4-bit word index and 16 data bits. The block holds a 10-bit wiper position and a bank of sixteen 16-bit retained words, kept here as ordinary registers. It writes, saves, recalls and reads back the wiper and the words. It also moves the wiper by single steps or by a factor of two (a 6 dB step).

An operation takes effect only when chip select returns high after exactly 24 serial clocks. While a frame is clocked in, the data output shifts out the previous 24 bits, so several devices can be chained. A read operation replaces the low 16 bits of that outgoing stream with the selected value, so the value appears during the following frame. The serial pins are sampled with the block's own fast clock, and the serial clock is treated as data. The data output comes with a separate drive enable, and the pad uses that enable to release the line.

Top module: `dpot_spi_core`

## Requirements
- R1: A frame is sent MSB first. Bits 23:20 hold the op code, bits 19:16 the word index and bits 15:0 the data. The op code acts only when chip select rises after exactly 24 rising serial-clock edges. Any other count leaves the wiper, the words and the flag unchanged.
- R2: Reset sets word 0 to the INIT_WORD0 parameter and all other words to zero. In the first clock after reset is released, the wiper loads bits 9:0 of word 0.
- R3: Op 11 loads the wiper from data bits 9:0. Op 3 writes all 16 data bits to the indexed word. Op 2 saves the wiper, zero-extended, into word 0. Ops 1 and 8 load the wiper from bits 9:0 of word 0. Op 0 and the read ops change neither the wiper nor any word.
- R4: Ops 14 and 15 add one to the wiper and stop at 1023. Ops 6 and 7 subtract one and stop at 0.
- R5: Ops 12 and 13 double the wiper. A wiper of 0 becomes 1, and a result above 1023 becomes 1023. Ops 4 and 5 halve the wiper with a logical right shift.
- R6: The step and doubling/halving ops give the same result whatever the 16 data bits hold.
- R7: The recall flag output is set by op 1 and cleared only by op 0. Every other op leaves it unchanged, and reset clears it.
- R8: When chip select falls, SDO presents bit 23 of the 24-bit serial register. After each falling serial-clock edge it presents the new bit 23, and SDI is shifted in on each rising serial-clock edge. A frame therefore shifts out the last 24 bits shifted in. The serial register resets to zero.
- R9: After op 9 executes, bits 15:0 of the serial register take the indexed word. After op 10 they take the zero-extended wiper. These bits are shifted out during the next frame, and bits 23:16 still carry the read frame's op code and index.
- R10: The drive enable sdoEn is high only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least eight times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Drive enable for the SDO pad |
| wiper | output | 10 | Current wiper position |
| readProgFlag | output | 1 | Recall flag, set by op 1 and cleared by op 0 |

## Verification
The hardest case to reach from the ports is a read result crossing into the next frame. The value is put into the serial register only at the moment chip select rises, and it can only be observed as bits 8 to 23 of the frame that follows. The bench sends each read op and then a complete 24-bit frame. It checks those shifted-out bits against a word it wrote earlier, and checks that the upper byte still carries the read frame's own op code and index. Aborted frames of 23 and 25 clocks are sent between real ones. These show that the partial shift reaches SDO but has no effect on the wiper or the words.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int FRAME_W = 24;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int WORDS   = 1 << ADDR_W;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP     = 4'd0,
    OP_RESTORE = 4'd1,
    OP_STORE   = 4'd2,
    OP_WRWORD  = 4'd3,
    OP_DEC6A   = 4'd4,
    OP_DEC6B   = 4'd5,
    OP_DEC1A   = 4'd6,
    OP_DEC1B   = 4'd7,
    OP_RESET   = 4'd8,
    OP_RDWORD  = 4'd9,
    OP_RDWIPER = 4'd10,
    OP_WRWIPER = 4'd11,
    OP_INC6A   = 4'd12,
    OP_INC6B   = 4'd13,
    OP_INC1A   = 4'd14,
    OP_INC1B   = 4'd15
  } op_e;

  // strobe bundle from serial control to the wiper datapath
  typedef struct packed {
    logic              exec;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_strobe_t;
endpackage

// File: rtl/dpot_serial_ctrl.sv
module dpot_serial_ctrl
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] readWord,
  output cmd_strobe_t       cmdStb,
  output logic              sdo,
  output logic              sdoEn
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               csQ, sclkQ, sdoBit;
  logic               csFall, csRise, sclkRise, sclkFall, isRead;

  assign csFall   = ~csN & csQ;
  assign csRise   = csN & ~csQ;
  assign sclkRise = ~csN & sclk & ~sclkQ;
  assign sclkFall = ~csN & ~sclk & sclkQ;

  always_comb begin
    cmdStb.exec = csRise && (bitCnt == CNT_FULL);
    cmdStb.op   = op_e'(shiftReg[FRAME_W-1 -: CMD_W]);
    cmdStb.addr = shiftReg[DATA_W +: ADDR_W];
    cmdStb.data = shiftReg[DATA_W-1:0];
  end

  assign isRead = cmdStb.exec &&
                  (cmdStb.op == OP_RDWORD || cmdStb.op == OP_RDWIPER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ      <= 1'b1;
      sclkQ    <= 1'b0;
      shiftReg <= '0;
      bitCnt   <= '0;
      sdoBit   <= 1'b0;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
      if (csFall) begin
        bitCnt <= '0;
        sdoBit <= shiftReg[FRAME_W-1];
      end else if (sclkRise) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], sdi};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + CNT_W'(1);
      end else if (sclkFall) begin
        sdoBit <= shiftReg[FRAME_W-1];
      end
      if (isRead) shiftReg[DATA_W-1:0] <= readWord;
    end
  end

  assign sdo   = sdoBit;
  assign sdoEn = ~csN;
endmodule

// File: rtl/dpot_wiper_path.sv
module dpot_wiper_path
  import dpot_pkg::*;
#(
  parameter int                WIPER_W    = 10,
  parameter logic [DATA_W-1:0] INIT_WORD0 = 16'h0200
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmd_strobe_t        cmdStb,
  output logic [WIPER_W-1:0] wiper,
  output logic               readProgFlag,
  output logic               bootPending,
  output logic [DATA_W-1:0]  readWord
);
  localparam logic [WIPER_W-1:0] W_MAX = '1;

  logic [DATA_W-1:0]  words [WORDS];
  logic [WIPER_W-1:0] wiperQ, wiperNext;

  always_comb begin
    wiperNext = wiperQ;
    if (bootPending) begin
      wiperNext = words[0][WIPER_W-1:0];
    end else if (cmdStb.exec) begin
      case (cmdStb.op)
        OP_RESTORE, OP_RESET: wiperNext = words[0][WIPER_W-1:0];
        OP_WRWIPER:           wiperNext = cmdStb.data[WIPER_W-1:0];
        OP_INC1A, OP_INC1B:   if (wiperQ != W_MAX) wiperNext = wiperQ + WIPER_W'(1);
        OP_DEC1A, OP_DEC1B:   if (wiperQ != '0) wiperNext = wiperQ - WIPER_W'(1);
        OP_INC6A, OP_INC6B: begin
          if (wiperQ == '0)             wiperNext = WIPER_W'(1);
          else if (wiperQ[WIPER_W-1])   wiperNext = W_MAX;
          else                          wiperNext = {wiperQ[WIPER_W-2:0], 1'b0};
        end
        OP_DEC6A, OP_DEC6B:   wiperNext = {1'b0, wiperQ[WIPER_W-1:1]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperQ       <= '0;
      bootPending  <= 1'b1;
      readProgFlag <= 1'b0;
    end else begin
      wiperQ      <= wiperNext;
      bootPending <= 1'b0;
      if (cmdStb.exec && cmdStb.op == OP_NOP)     readProgFlag <= 1'b0;
      if (cmdStb.exec && cmdStb.op == OP_RESTORE) readProgFlag <= 1'b1;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? INIT_WORD0 : '0;
    logic wrData, wrSave;
    assign wrData = cmdStb.exec && cmdStb.op == OP_WRWORD &&
                    cmdStb.addr == ADDR_W'(g);
    assign wrSave = (g == 0) && cmdStb.exec && cmdStb.op == OP_STORE;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       words[g] <= RST_VAL;
      else if (wrData) words[g] <= cmdStb.data;
      else if (wrSave) words[g] <= DATA_W'(wiperQ);
    end
  end

  assign readWord = (cmdStb.op == OP_RDWORD) ? words[cmdStb.addr] : DATA_W'(wiperQ);
  assign wiper    = wiperQ;
endmodule

// File: rtl/dpot_spi_core.sv
module dpot_spi_core
  import dpot_pkg::*;
#(
  parameter int                WIPER_W    = 10,
  parameter logic [DATA_W-1:0] INIT_WORD0 = 16'h0200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdoEn,
  output logic [WIPER_W-1:0] wiper,
  output logic               readProgFlag
);
  cmd_strobe_t       cmdStb;
  logic [DATA_W-1:0] readWord;
  logic              bootPending;

  dpot_serial_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .readWord(readWord), .cmdStb(cmdStb), .sdo(sdo), .sdoEn(sdoEn)
  );

  dpot_wiper_path #(.WIPER_W(WIPER_W), .INIT_WORD0(INIT_WORD0)) u_path (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .wiper(wiper),
    .readProgFlag(readProgFlag), .bootPending(bootPending), .readWord(readWord)
  );
endmodule

// File: rtl/dpot_spi_core_checker.sv
module dpot_spi_core_checker
  import dpot_pkg::*;
#(
  parameter int WIPER_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               sdoEn,
  input logic               readProgFlag,
  input logic               bootPending,
  input logic [WIPER_W-1:0] wiper,
  input cmd_strobe_t        cmdStb
);
  localparam logic [WIPER_W-1:0] W_MAX = '1;

  assert_exec_on_cs_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb.exec |-> $rose(csN));

  assert_quiet_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdStb.exec && !bootPending) |=> $stable(wiper));

  assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb.exec && (cmdStb.op == OP_INC1A || cmdStb.op == OP_INC1B) && wiper != W_MAX)
    |=> wiper == $past(wiper) + WIPER_W'(1));

  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb.exec && (cmdStb.op == OP_DEC1A || cmdStb.op == OP_DEC1B) && wiper != '0)
    |=> wiper == $past(wiper) - WIPER_W'(1));

  assert_halve_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb.exec && (cmdStb.op == OP_DEC6A || cmdStb.op == OP_DEC6B))
    |=> wiper == ($past(wiper) >> 1));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb.exec && cmdStb.op == OP_RESTORE) |=> readProgFlag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb.exec && cmdStb.op == OP_NOP) |=> !readProgFlag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdStb.exec || (cmdStb.op != OP_NOP && cmdStb.op != OP_RESTORE))
    |=> $stable(readProgFlag));

  assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !sdoEn);
endmodule

bind dpot_spi_core dpot_spi_core_checker #(.WIPER_W(WIPER_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoEn(sdoEn),
  .readProgFlag(readProgFlag), .bootPending(bootPending),
  .wiper(wiper), .cmdStb(cmdStb)
);

// File: tb/dpot_spi_core_bench.sv
`timescale 1ns/1ps
module dpot_spi_core_bench;
  localparam int HALF = 4;
  localparam logic [15:0] INIT0 = 16'h0200;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoEn, readProgFlag;
  logic [9:0] wiper;

  int nChecks = 0, nFails = 0;
  bit cmpOn = 0;

  int          mw;
  int          mwords[16];
  bit          mflag;
  logic [23:0] msr;
  logic [23:0] got;

  always #2 clk = ~clk;

  dpot_spi_core #(.WIPER_W(10), .INIT_WORD0(INIT0)) u_dpot_spi_core (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .wiper(wiper), .readProgFlag(readProgFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endfunction

  // per-clock comparison against the behavioural model
  always @(posedge clk) begin
    #1;
    if (cmpOn) begin
      chk("R3 R4 R5 wiper vs model", int'(wiper), mw);
      chk("R7 flag vs model", int'(readProgFlag), int'(mflag));
    end
  end

  task automatic modelExec(input logic [23:0] f);
    int c = int'(f[23:20]);
    int a = int'(f[19:16]);
    int d = int'(f[15:0]);
    case (c)
      0:      mflag = 0;
      1:      begin mw = mwords[0] % 1024; mflag = 1; end
      2:      mwords[0] = mw;
      3:      mwords[a] = d;
      4, 5:   mw = mw / 2;
      6, 7:   if (mw > 0) mw = mw - 1;
      8:      mw = mwords[0] % 1024;
      9:      msr[15:0] = 16'(mwords[a]);
      10:     msr[15:0] = 16'(mw);
      11:     mw = d % 1024;
      12, 13: mw = (mw == 0) ? 1 : ((mw * 2 > 1023) ? 1023 : mw * 2);
      default: if (mw < 1023) mw = mw + 1;
    endcase
  endtask

  task automatic frame(input logic [23:0] v, input int n);
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 24) ? v[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      chk("R8 R9 sdo bit", int'(sdo), int'(msr[23]));
      chk("R10 enable while selected", int'(sdoEn), 1);
      got = {got[22:0], sdo};
      sclk = 1'b1;
      msr = {msr[22:0], sdi};
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csN = 1'b1;
    if (n == 24) modelExec(msr);
    repeat (3) @(negedge clk);
    chk("R10 released while deselected", int'(sdoEn), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    mw = 0; mflag = 0; msr = '0; got = '0;
    for (int i = 0; i < 16; i++) mwords[i] = 0;
    mwords[0] = int'(INIT0);
    repeat (3) @(negedge clk);
    chk("R2 wiper in reset", int'(wiper), 0);
    chk("R7 flag in reset", int'(readProgFlag), 0);
    chk("R10 enable in reset", int'(sdoEn), 0);
    rstN = 1'b1;
    mw = int'(INIT0) % 1024;
    cmpOn = 1;
    repeat (2) @(negedge clk);
    chk("R2 power-on recall", int'(wiper), 512);

    frame(24'hA00000, 24);
    frame(24'h000000, 24);
    chk("R9 wiper read-back", int'(got[15:0]), 512);
    chk("R9 upper byte keeps read frame", int'(got[23:16]), 8'hA0);

    frame(24'hB003FF, 24); chk("R3 wiper write", int'(wiper), 1023);
    frame(24'hE00000, 24); chk("R4 increment saturates", int'(wiper), 1023);
    frame(24'hC00000, 24); chk("R5 doubling saturates", int'(wiper), 1023);
    frame(24'h400000, 24); chk("R5 halving", int'(wiper), 511);
    frame(24'hD00000, 24); chk("R5 doubling alias 13", int'(wiper), 1022);
    frame(24'hB00000, 24); chk("R3 wiper write zero", int'(wiper), 0);
    frame(24'h700000, 24); chk("R4 decrement floor", int'(wiper), 0);
    frame(24'h500000, 24); chk("R5 halving zero", int'(wiper), 0);
    frame(24'hC00000, 24); chk("R5 doubling from zero", int'(wiper), 1);
    frame(24'hF0FFFF, 24); chk("R6 increment ignores data", int'(wiper), 2);
    frame(24'h60ABCD, 24); chk("R6 decrement ignores data", int'(wiper), 1);

    frame(24'h37BEEF, 24);
    frame(24'h970000, 24);
    frame(24'h000000, 24);
    chk("R9 word read-back", int'(got[15:0]), 16'hBEEF);
    chk("R8 daisy carries read frame head", int'(got[23:16]), 8'h97);

    frame(24'hB00155, 24);
    frame(24'h200000, 24);
    frame(24'hB00003, 24); chk("R3 write before recall", int'(wiper), 3);
    frame(24'h100000, 24);
    chk("R3 recall from word 0", int'(wiper), 16'h155);
    chk("R7 recall sets flag", int'(readProgFlag), 1);
    frame(24'hB00010, 24); chk("R7 flag kept by write", int'(readProgFlag), 1);
    frame(24'h000000, 24); chk("R7 NOP clears flag", int'(readProgFlag), 0);
    frame(24'h800000, 24); chk("R3 reset op recall", int'(wiper), 16'h155);

    frame(24'hB00222, 23); chk("R1 short frame ignored", int'(wiper), 16'h155);
    frame(24'hB00222, 25); chk("R1 long frame ignored", int'(wiper), 16'h155);
    frame(24'hB00222, 24); chk("R1 exact frame acts", int'(wiper), 16'h222);
    frame(24'h000000, 24);
    chk("R8 daisy shifts previous frame", int'(got), 24'hB00222);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule